// File: doc/BRIEF.md
# Serial Lane Frame Builder

This block takes whole payloads from an upstream byte source and sends each one out as a framed symbol stream for a single serial lane. Every frame opens with a short training run, so that the far end can lock its clock recovery. A start marker follows. The body is a sequence number, the payload and a 16-bit check value. An end marker closes the frame. The symbol output is one byte wide. A control flag beside it separates marker and training symbols from ordinary data.

Payloads are written into a replay store that holds a fixed number of frames. The frames are sent from the store in the order they were accepted. Each frame stays in the store until the far end acknowledges it. An acknowledge names one sequence number and releases that frame and every older one. A replay request names a held sequence number. The transmitter finishes the frame it is sending, then goes back to the named frame and resends it and every frame after it. Intake pauses while the store is full, and from the moment a replay is requested until the resend has caught up.

Top module: `link_framer`

## Requirements
- R1: After reset, `sym_valid` is 0 and `in_ready` is 1.
- R2: Each frame is sent as the following symbols, in this order:
  - 4 training symbols 0xBC, with `sym_ctrl`=1.
  - The start marker 0xFB, with `sym_ctrl`=1.
  - The sequence number as two bytes, high byte first. The high byte is the upper 4 bits of the 12-bit number, zero-padded.
  - The payload bytes.
  - The check value, high byte first.
  - The end marker 0xFD, with `sym_ctrl`=1.

  Every sequence, payload and check byte carries `sym_ctrl`=0.
- R3: Once a frame's first training symbol has appeared, `sym_valid` stays 1 on every cycle until that frame's end marker.
- R4: The check value is a CRC-16 computed as follows:
  - Polynomial 0x1021, start value 0xFFFF, no final inversion.
  - Bits are fed most significant bit first.
  - It covers the two sequence bytes and the payload bytes.
- R5: The first frame after reset carries sequence number 0. Each newly accepted frame carries the previous number plus one, wrapping from 4095 to 0.
- R6: Frames are sent in the order they were accepted. Up to 8 frames may be held without acknowledgment. `in_ready` is 0 while 8 frames are held.
- R7: An acknowledge frees the named frame and all older frames, provided the named frame has already been sent completely. An acknowledge naming any other sequence number is ignored.
- R8: A replay request takes effect once the current frame has ended. Transmission then restarts at the requested frame and resends it and all later held frames. `in_ready` is 0 from the cycle after the request until the resend reaches the newest accepted frame.
- R9: A replay request for a sequence number that is not held is ignored, and no symbols are sent because of it.
- R10: A payload longer than 64 bytes is cut to its first 64 bytes. The bytes beyond are accepted and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream byte is valid |
| in_ready | output | 1 | Block accepts an upstream byte |
| in_data | input | 8 | Upstream payload byte |
| in_last | input | 1 | Marks the final byte of a payload |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_seq | input | 12 | Newest sequence number being acknowledged |
| replay_valid | input | 1 | Replay request strobe |
| replay_seq | input | 12 | Sequence number to restart from |
| sym_valid | output | 1 | Symbol output is valid |
| sym_data | output | 8 | Symbol byte |
| sym_ctrl | output | 1 | 1 for training and marker symbols |

## Verification
The bench builds the block with its default parameters: a 12-bit sequence number, eight frame slots and 64-byte payloads. With these values the bench can run a full wrap of the sequence counter, about four thousand one-byte frames, in roughly fifty thousand cycles. The same values let it fill the store in eight frames and exercise the largest payload and its truncation directly. Replays are tested both between frames and in the middle of a frame, together with acknowledges that release several frames at once.

// File: rtl/lf_pkg.sv
package lf_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_TRAIN, S_SOF, S_SQH, S_SQL, S_PAY, S_CRH, S_CRL, S_EOF
  } tx_state_t;

  localparam logic [7:0] SYM_TRAIN = 8'hBC;
  localparam logic [7:0] SYM_SOF   = 8'hFB;
  localparam logic [7:0] SYM_EOF   = 8'hFD;

  // one byte of CRC-16, polynomial 0x1021, msb first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

endpackage

// File: rtl/lf_store.sv
module lf_store #(
  parameter int SLOTS   = 8,
  parameter int MAX_LEN = 64
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [$clog2(SLOTS)-1:0]   wr_slot,
  input  logic [$clog2(MAX_LEN)-1:0] wr_idx,
  input  logic [7:0]                 wr_data,
  input  logic                       len_we,
  input  logic [$clog2(MAX_LEN)-1:0] len_val,
  input  logic [$clog2(SLOTS)-1:0]   rd_slot,
  input  logic [$clog2(MAX_LEN)-1:0] rd_idx,
  output logic [7:0]                 rd_data,
  output logic [$clog2(MAX_LEN)-1:0] len_last
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(MAX_LEN);
  localparam int WORDS  = SLOTS * MAX_LEN;

  logic [7:0]       mem  [WORDS];
  logic [IDX_W-1:0] lens [SLOTS];

  // simple dual-port byte store with registered read
  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_slot, wr_idx}] <= wr_data;
    rd_data <= mem[{rd_slot, rd_idx}];
  end

  // last payload index of each slot, written at the payload's final byte
  always_ff @(posedge clk) begin
    if (len_we) lens[wr_slot] <= len_val;
  end

  assign len_last = lens[rd_slot];
endmodule

// File: rtl/lf_tx.sv
module lf_tx
  import lf_pkg::*;
#(
  parameter int SEQ_W     = 12,
  parameter int SLOTS     = 8,
  parameter int MAX_LEN   = 64,
  parameter int TRAIN_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SEQ_W-1:0]           head,
  input  logic [SEQ_W-1:0]           tail,
  input  logic                       rep_pend,
  input  logic [SEQ_W-1:0]           rep_seq,
  input  logic                       ack_hit,
  input  logic [7:0]                 rd_data,
  input  logic [$clog2(MAX_LEN)-1:0] len_last,
  output logic [$clog2(SLOTS)-1:0]   rd_slot,
  output logic [$clog2(MAX_LEN)-1:0] rd_idx,
  output logic [SEQ_W-1:0]           send_seq,
  output logic                       replay_act,
  output logic                       rep_take,
  output logic                       sym_valid,
  output logic [7:0]                 sym_data,
  output logic                       sym_ctrl
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(MAX_LEN);
  localparam int TC_W   = $clog2(TRAIN_LEN);
  localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

  tx_state_t        state;
  logic [TC_W-1:0]  tcnt;
  logic [IDX_W-1:0] bidx;
  logic [15:0]      crc;
  logic [15:0]      seq16;
  logic [SEQ_W-1:0] held, rep_off, seq_nx;

  assign seq16    = 16'(send_seq);
  assign held     = tail - head;
  assign rep_off  = rep_seq - head;
  assign seq_nx   = send_seq + SEQ_ONE;
  assign rep_take = (state == S_IDLE) && rep_pend && !ack_hit;
  assign rd_slot  = send_seq[SLOT_W-1:0];
  // prefetch: the byte shown in S_PAY was addressed one cycle earlier
  assign rd_idx   = (state == S_PAY) ? bidx + IDX_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      crc        <= 16'hFFFF;
      send_seq   <= '0;
      replay_act <= 1'b0;
      sym_valid  <= 1'b0;
      sym_data   <= '0;
      sym_ctrl   <= 1'b0;
    end else begin
      sym_valid <= 1'b0;
      sym_ctrl  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (rep_take) begin
            if (rep_off < held) begin
              send_seq   <= rep_seq;
              replay_act <= 1'b1;
            end
          end else if (!rep_pend && send_seq != tail) begin
            state <= S_TRAIN;
            tcnt  <= '0;
          end
        end
        S_TRAIN: begin
          sym_valid <= 1'b1;
          sym_ctrl  <= 1'b1;
          sym_data  <= SYM_TRAIN;
          tcnt      <= tcnt + TC_W'(1);
          if (tcnt == TC_W'(TRAIN_LEN - 1)) state <= S_SOF;
        end
        S_SOF: begin
          sym_valid <= 1'b1;
          sym_ctrl  <= 1'b1;
          sym_data  <= SYM_SOF;
          crc       <= 16'hFFFF;
          state     <= S_SQH;
        end
        S_SQH: begin
          sym_valid <= 1'b1;
          sym_data  <= seq16[15:8];
          crc       <= crc16_byte(crc, seq16[15:8]);
          state     <= S_SQL;
        end
        S_SQL: begin
          sym_valid <= 1'b1;
          sym_data  <= seq16[7:0];
          crc       <= crc16_byte(crc, seq16[7:0]);
          bidx      <= '0;
          state     <= S_PAY;
        end
        S_PAY: begin
          sym_valid <= 1'b1;
          sym_data  <= rd_data;
          crc       <= crc16_byte(crc, rd_data);
          bidx      <= bidx + IDX_W'(1);
          if (bidx == len_last) state <= S_CRH;
        end
        S_CRH: begin
          sym_valid <= 1'b1;
          sym_data  <= crc[15:8];
          state     <= S_CRL;
        end
        S_CRL: begin
          sym_valid <= 1'b1;
          sym_data  <= crc[7:0];
          state     <= S_EOF;
        end
        S_EOF: begin
          sym_valid <= 1'b1;
          sym_ctrl  <= 1'b1;
          sym_data  <= SYM_EOF;
          send_seq  <= seq_nx;
          if (seq_nx == tail) replay_act <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_framer.sv
module link_framer #(
  parameter int SEQ_W   = 12,
  parameter int SLOTS   = 8,
  parameter int MAX_LEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             ack_valid,
  input  logic [SEQ_W-1:0] ack_seq,
  input  logic             replay_valid,
  input  logic [SEQ_W-1:0] replay_seq,
  output logic             sym_valid,
  output logic [7:0]       sym_data,
  output logic             sym_ctrl
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(MAX_LEN);
  localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);
  localparam logic [SEQ_W-1:0] CAP     = SEQ_W'(SLOTS);

  logic [SEQ_W-1:0]  head_q, tail_q, send_seq, rep_seq_q;
  logic [SEQ_W-1:0]  held, sent, ack_off;
  logic [IDX_W:0]    widx;
  logic              rep_pend_q, rep_take, replay_act;
  logic              accept, wr_en, ack_hit;
  logic [IDX_W-1:0]  len_val, rd_idx, len_last;
  logic [SLOT_W-1:0] rd_slot;
  logic [7:0]        rd_data;

  assign held     = tail_q - head_q;
  assign sent     = send_seq - head_q;
  assign ack_off  = ack_seq - head_q;
  assign ack_hit  = ack_valid && (ack_off < sent);
  assign in_ready = (held != CAP) && !rep_pend_q && !replay_act;
  assign accept   = in_valid && in_ready;
  assign wr_en    = accept && !widx[IDX_W];
  assign len_val  = widx[IDX_W] ? {IDX_W{1'b1}} : widx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q     <= '0;
      tail_q     <= '0;
      widx       <= '0;
      rep_pend_q <= 1'b0;
      rep_seq_q  <= '0;
    end else begin
      if (accept) begin
        if (in_last) begin
          widx   <= '0;
          tail_q <= tail_q + SEQ_ONE;
        end else if (!widx[IDX_W]) begin
          widx <= widx + (IDX_W+1)'(1);
        end
      end
      if (ack_hit) head_q <= ack_seq + SEQ_ONE;
      if (replay_valid) begin
        rep_pend_q <= 1'b1;
        rep_seq_q  <= replay_seq;
      end else if (rep_take) begin
        rep_pend_q <= 1'b0;
      end
    end
  end

  lf_store #(.SLOTS(SLOTS), .MAX_LEN(MAX_LEN)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_slot  (tail_q[SLOT_W-1:0]),
    .wr_idx   (widx[IDX_W-1:0]),
    .wr_data  (in_data),
    .len_we   (accept && in_last),
    .len_val  (len_val),
    .rd_slot  (rd_slot),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .len_last (len_last)
  );

  lf_tx #(.SEQ_W(SEQ_W), .SLOTS(SLOTS), .MAX_LEN(MAX_LEN), .TRAIN_LEN(4)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .head       (head_q),
    .tail       (tail_q),
    .rep_pend   (rep_pend_q),
    .rep_seq    (rep_seq_q),
    .ack_hit    (ack_hit),
    .rd_data    (rd_data),
    .len_last   (len_last),
    .rd_slot    (rd_slot),
    .rd_idx     (rd_idx),
    .send_seq   (send_seq),
    .replay_act (replay_act),
    .rep_take   (rep_take),
    .sym_valid  (sym_valid),
    .sym_data   (sym_data),
    .sym_ctrl   (sym_ctrl)
  );
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int SEQ_W = 12,
  parameter int SLOTS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic [7:0]       sym_data,
  input logic             sym_ctrl,
  input logic             in_ready,
  input logic [SEQ_W-1:0] head,
  input logic [SEQ_W-1:0] tail,
  input logic [SEQ_W-1:0] send_seq
);
  localparam logic [SEQ_W-1:0] CAP = SEQ_W'(SLOTS);

  a_r2_ctrl_codes: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_ctrl) |-> (sym_data == 8'hBC || sym_data == 8'hFB || sym_data == 8'hFD));

  a_r2_start_after_train: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_ctrl && sym_data == 8'hFB) |-> $past(sym_valid && sym_ctrl && sym_data == 8'hBC));

  a_r2_end_after_check: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_ctrl && sym_data == 8'hFD) |-> $past(sym_valid && !sym_ctrl));

  a_r3_no_gap: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !(sym_ctrl && sym_data == 8'hFD)) |=> sym_valid);

  a_r6_window_bound: assert property (@(posedge clk) disable iff (rst)
    (tail - head) <= CAP);

  a_r6_full_stalls: assert property (@(posedge clk) disable iff (rst)
    ((tail - head) == CAP) |-> !in_ready);

  a_r7_send_in_window: assert property (@(posedge clk) disable iff (rst)
    (send_seq - head) <= (tail - head));
endmodule

bind link_framer lf_checker #(.SEQ_W(SEQ_W), .SLOTS(SLOTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sym_valid (sym_valid),
  .sym_data  (sym_data),
  .sym_ctrl  (sym_ctrl),
  .in_ready  (in_ready),
  .head      (head_q),
  .tail      (tail_q),
  .send_seq  (send_seq)
);

// File: tb/link_framer_test.sv
module link_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 0, rst = 1;
  logic        in_valid = 0, in_last = 0, in_ready;
  logic [7:0]  in_data = 0;
  logic        ack_valid = 0, replay_valid = 0;
  logic [11:0] ack_seq = 0, replay_seq = 0;
  logic        sym_valid, sym_ctrl;
  logic [7:0]  sym_data;

  link_framer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .ack_valid(ack_valid),
    .ack_seq(ack_seq), .replay_valid(replay_valid), .replay_seq(replay_seq),
    .sym_valid(sym_valid), .sym_data(sym_data), .sym_ctrl(sym_ctrl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0, next_seq = 0;
  logic [8:0] cap_q[$];
  logic [8:0] exp_q[$];

  // frame monitor and acknowledge driver
  int   sym_pos = 0, gap_cnt = 0, man_cnt = 0, man_seen = 0;
  logic in_frame = 0, done_flag = 0, auto_ack = 0;
  logic [11:0] cur_seq = 0, done_seq = 0, man_seq = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sym_valid) begin
        cap_q.push_back({sym_ctrl, sym_data});
        if (!in_frame) begin in_frame = 1; sym_pos = 0; end
        if (sym_pos == 5) cur_seq[11:8] = sym_data[3:0];
        if (sym_pos == 6) cur_seq[7:0]  = sym_data;
        if (sym_ctrl && sym_data == 8'hFD) begin
          in_frame = 0; done_seq = cur_seq; done_flag = 1;
        end
        sym_pos++;
      end else if (in_frame) gap_cnt++;
    end
    if (man_cnt != man_seen) begin
      man_seen = man_cnt; ack_valid = 1; ack_seq = man_seq;
    end else if (auto_ack && done_flag) begin
      ack_valid = 1; ack_seq = done_seq; done_flag = 0;
    end else begin
      ack_valid = 0;
      if (!auto_ack) done_flag = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] pb(input int s, input int i);
    return 8'(s * 7 + i * 13 + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  // expected symbols of one frame (R2, R4)
  task automatic exp_frame(input int s, input int len);
    logic [15:0] c = 16'hFFFF;
    logic [7:0]  hi = {4'h0, 4'(s >> 8)}, lo = 8'(s);
    for (int i = 0; i < 4; i++) exp_q.push_back({1'b1, 8'hBC});
    exp_q.push_back({1'b1, 8'hFB});
    exp_q.push_back({1'b0, hi}); c = bcrc(c, hi);
    exp_q.push_back({1'b0, lo}); c = bcrc(c, lo);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back({1'b0, pb(s, i)}); c = bcrc(c, pb(s, i));
    end
    exp_q.push_back({1'b0, c[15:8]});
    exp_q.push_back({1'b0, c[7:0]});
    exp_q.push_back({1'b1, 8'hFD});
  endtask

  task automatic send_frame(input int nb, input bit expect_it = 1);
    int s = next_seq;
    for (int i = 0; i < nb; i++) begin
      in_valid = 1; in_data = pb(s, i); in_last = (i == nb - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    if (expect_it) exp_frame(s, nb > 64 ? 64 : nb);
    next_seq = (s + 1) % 4096;
  endtask

  task automatic quiet();
    int idle = 0;
    while (idle < 24) begin
      @(negedge clk);
      idle = sym_valid ? 0 : idle + 1;
    end
  endtask

  task automatic man_ack(input int s);
    @(posedge clk);
    man_seq = 12'(s); man_cnt++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_replay(input int s);
    replay_valid = 1; replay_seq = 12'(s);
    @(negedge clk);
    replay_valid = 0;
  endtask

  task automatic compare(input string tag);
    int n = (cap_q.size() < exp_q.size()) ? cap_q.size() : exp_q.size();
    int bad = -1;
    for (int i = 0; i < n; i++) if (bad < 0 && cap_q[i] !== exp_q[i]) bad = i;
    n_run++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: symbol %0d got %h expected %h", tag, bad, cap_q[bad], exp_q[bad]);
    end else if (cap_q.size() != exp_q.size()) begin
      n_fail++;
      $display("FAIL %s: got %0d symbols expected %0d", tag, cap_q.size(), exp_q.size());
    end
    cap_q.delete(); exp_q.delete();
  endtask

  task automatic t_reset();
    check(sym_valid === 1'b0, "R1 sym_valid after reset", sym_valid, 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_crc_anchor();
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 9; i++) c = bcrc(c, 8'h31 + 8'(i));
    check(c == 16'h29B1, "R4 check value anchor", c, 16'h29B1);
  endtask

  task automatic t_basic();
    send_frame(5);
    quiet();
    compare("R2 R4 R5 single frame");
    man_ack(next_seq - 1);
  endtask

  task automatic t_lengths();
    send_frame(1); send_frame(64); send_frame(17);
    quiet();
    compare("R6 order with lengths 1 64 17");
    man_ack(next_seq - 1);
  endtask

  task automatic t_overlen();
    send_frame(66);
    quiet();
    compare("R10 payload cut to 64");
    man_ack(next_seq - 1);
  endtask

  task automatic t_full();
    int first = next_seq;
    for (int k = 0; k < 8; k++) send_frame(3);
    check(in_ready === 1'b0, "R6 stall with 8 held", in_ready, 0);
    quiet();
    compare("R6 eight frames");
    man_ack(next_seq + 3);
    check(in_ready === 1'b0, "R7 ack of unheld number ignored", in_ready, 0);
    man_ack(first + 2);
    check(in_ready === 1'b1, "R7 ack frees older frames", in_ready, 1);
    do_replay(first + 1);
    quiet();
    compare("R7 R9 replay of freed frame sends nothing");
    man_ack(next_seq - 1);
  endtask

  task automatic t_replay();
    int s = next_seq;
    send_frame(4); send_frame(2); send_frame(9);
    quiet();
    compare("R8 frames before replay");
    do_replay(s + 1);
    check(in_ready === 1'b0, "R8 intake paused on replay", in_ready, 0);
    exp_frame(s + 1, 2); exp_frame(s + 2, 9);
    quiet();
    compare("R8 resend from requested frame");
    check(in_ready === 1'b1, "R8 intake resumes after resend", in_ready, 1);
    send_frame(6);
    while (!sym_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    do_replay(s + 3);
    exp_frame(s + 3, 6);
    quiet();
    compare("R8 replay waits for frame end");
    man_ack(next_seq - 1);
  endtask

  task automatic t_wrap();
    auto_ack = 1;
    do send_frame(1); while (next_seq != 3);
    quiet();
    auto_ack = 0;
    compare("R5 sequence wraps 4095 to 0");
    check(gap_cnt == 0, "R3 no gap inside a frame", gap_cnt, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_crc_anchor();
    t_basic();
    t_lengths();
    t_overlen();
    t_full();
    t_replay();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule